// File: doc/BRIEF.md
# Temperature Result Register with Read-Coherent Update

This block sits between a temperature converter and a two-wire host interface. Each time the converter signals a finished conversion, the block turns the 12-bit raw sample into a 16-bit, left-justified two's-complement word. It then zeroes every bit below the selected resolution and registers the result.

There are two copies of the result. The comparison copy feeds the thermal alarm logic, and every finished conversion loads it. The readable copy is what the host reads back. A conversion that finishes while the bus interface reports a read in progress leaves the readable copy unchanged, so a multi-byte read never mixes bytes from two samples. The readable copy catches up at the next finished conversion that does not overlap a read.

Top module: `temp_result_reg`

## Requirements
- R1: After reset both `temp_word_o` and `cmp_word_o` are 16'h0000.
- R2: Raw sample bit 11 lands in word bit 15 and serves as the sign bit. The sample is left-justified, so raw bit n goes to word bit n+4. Word bits 3:0 are always zero.
- R3: The resolution code on `res_sel_i` selects how many significant bits are kept. Code 0 keeps 9 bits and zeroes word bits 6:0. Code 1 keeps 10 bits and zeroes bits 5:0. Code 2 keeps 11 bits and zeroes bits 4:0. Code 3 keeps 12 bits and zeroes only bits 3:0.
- R4: On every cycle with `conv_done_i` high, `cmp_word_o` takes the masked sample one clock later. `rd_busy_i` has no effect on this update.
- R5: On a cycle with `conv_done_i` high and `rd_busy_i` low, `temp_word_o` takes the masked sample one clock later.
- R6: On a cycle with `conv_done_i` and `rd_busy_i` both high, `temp_word_o` keeps its previous value.
- R7: A sample skipped under R6 never appears on `temp_word_o`. The next change of `temp_word_o` carries the first later sample that arrives with `rd_busy_i` low.
- R8: With `conv_done_i` low, both outputs hold their values. A change of `res_sel_i` alone leaves both outputs unchanged. The new code applies from the next conversion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_done_i | input | 1 | One-cycle strobe: a conversion result is present on conv_raw_i |
| conv_raw_i | input | 12 | Raw two's-complement conversion sample |
| res_sel_i | input | 2 | Resolution code, 0..3 for 9..12 bits |
| rd_busy_i | input | 1 | High while the host is reading a register |
| temp_word_o | output | 16 | Host-readable temperature word |
| cmp_word_o | output | 16 | Comparison copy for the alarm logic |

## Verification
The bench applies strobes while a read is in progress, including several in a row. A design that lets those samples through would show a torn or early value on the readable word. A design that also held back the comparison copy would delay the alarm. The bench checks that the first unmasked strobe after a masked run delivers its own sample and not an older skipped one. It sweeps all four resolution codes on an all-ones sample, where an off-by-one mask leaves a stray one or clears a valid bit. It also changes the code with no strobe present, to catch a design that re-masks the stored word when the code changes.

// File: rtl/temp_result_pkg.sv
package temp_result_pkg;
    localparam int TR_RAW_W    = 12;
    localparam int TR_WORD_W   = 16;
    localparam int TR_RES_W    = 2;
    localparam int TR_MIN_BITS = 9;
endpackage

// File: rtl/tr_res_mask.sv
module tr_res_mask #(
    parameter int RAW_W    = temp_result_pkg::TR_RAW_W,
    parameter int WORD_W   = temp_result_pkg::TR_WORD_W,
    parameter int RES_W    = temp_result_pkg::TR_RES_W,
    parameter int MIN_BITS = temp_result_pkg::TR_MIN_BITS
) (
    input  logic [RAW_W-1:0]  raw_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int PAD_W  = WORD_W - RAW_W;
    // raw bit index below which bits are dropped at the coarsest setting
    localparam int CUT_LO = RAW_W - MIN_BITS;

    logic [RAW_W-1:0] keep;

    generate
        for (genvar k = 0; k < RAW_W; k++) begin : g_bit
            assign keep[k] = (32'(k) + 32'(res_i)) >= 32'(CUT_LO);
            assign word_o[PAD_W + k] = raw_i[k] & keep[k];
        end
        if (PAD_W > 0) begin : g_pad
            assign word_o[PAD_W-1:0] = '0;
        end
    endgenerate
endmodule

// File: rtl/tr_capture.sv
module tr_capture #(
    parameter int WORD_W = temp_result_pkg::TR_WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              done_i,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] rd_o,
    output logic [WORD_W-1:0] cmp_o
);
    typedef struct packed {
        logic [WORD_W-1:0] rd;
        logic [WORD_W-1:0] cmp;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            // alarm path sees every sample
            st_d.cmp = word_i;
            // readable copy skips samples that overlap a host read
            if (!busy_i) begin
                st_d.rd = word_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_o  = st_q.rd;
    assign cmp_o = st_q.cmp;
endmodule

// File: rtl/temp_result_reg.sv
module temp_result_reg #(
    parameter int RAW_W    = temp_result_pkg::TR_RAW_W,
    parameter int WORD_W   = temp_result_pkg::TR_WORD_W,
    parameter int RES_W    = temp_result_pkg::TR_RES_W,
    parameter int MIN_BITS = temp_result_pkg::TR_MIN_BITS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              conv_done_i,
    input  logic [RAW_W-1:0]  conv_raw_i,
    input  logic [RES_W-1:0]  res_sel_i,
    input  logic              rd_busy_i,
    output logic [WORD_W-1:0] temp_word_o,
    output logic [WORD_W-1:0] cmp_word_o
);
    logic [WORD_W-1:0] masked_word;

    tr_res_mask #(
        .RAW_W   (RAW_W),
        .WORD_W  (WORD_W),
        .RES_W   (RES_W),
        .MIN_BITS(MIN_BITS)
    ) u_mask (
        .raw_i (conv_raw_i),
        .res_i (res_sel_i),
        .word_o(masked_word)
    );

    tr_capture #(
        .WORD_W(WORD_W)
    ) u_cap (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .done_i(conv_done_i),
        .busy_i(rd_busy_i),
        .word_i(masked_word),
        .rd_o  (temp_word_o),
        .cmp_o (cmp_word_o)
    );
endmodule

// File: rtl/tr_checker.sv
module tr_checker #(
    parameter int RAW_W    = temp_result_pkg::TR_RAW_W,
    parameter int WORD_W   = temp_result_pkg::TR_WORD_W,
    parameter int RES_W    = temp_result_pkg::TR_RES_W,
    parameter int MIN_BITS = temp_result_pkg::TR_MIN_BITS
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              conv_done_i,
    input logic [RES_W-1:0]  res_sel_i,
    input logic              rd_busy_i,
    input logic [WORD_W-1:0] temp_word_o,
    input logic [WORD_W-1:0] cmp_word_o
);
    localparam int PAD_W   = WORD_W - RAW_W;
    localparam int COARSE0 = PAD_W + RAW_W - MIN_BITS;

    a_r2_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (temp_word_o[PAD_W-1:0] == '0) && (cmp_word_o[PAD_W-1:0] == '0));

    a_r3_coarse_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && res_sel_i == '0) |=> (cmp_word_o[COARSE0-1:0] == '0));

    a_r5_rd_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && !rd_busy_i) |=> (temp_word_o == cmp_word_o));

    a_r6_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && rd_busy_i) |=> $stable(temp_word_o));

    a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !conv_done_i |=> ($stable(temp_word_o) && $stable(cmp_word_o)));
endmodule

bind temp_result_reg tr_checker #(
    .RAW_W   (RAW_W),
    .WORD_W  (WORD_W),
    .RES_W   (RES_W),
    .MIN_BITS(MIN_BITS)
) u_tr_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_done_i(conv_done_i),
    .res_sel_i  (res_sel_i),
    .rd_busy_i  (rd_busy_i),
    .temp_word_o(temp_word_o),
    .cmp_word_o (cmp_word_o)
);

// File: tb/temp_result_reg_bench.sv
`timescale 1ns/100ps
module temp_result_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done = 1'b0;
    logic [11:0] raw = '0;
    logic [1:0]  res = '0;
    logic        busy = 1'b0;
    logic [15:0] temp_w, cmp_w;

    int vec_cnt = 0;
    int err_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] cmp;
        logic [15:0] rd;
        string       tag;
    } exp_item_t;

    exp_item_t   sb_q[$];
    logic [15:0] model_cmp = '0;
    logic [15:0] model_rd  = '0;
    bit          pend = 1'b0;

    always #2.5 clk = ~clk;

    temp_result_reg u_temp_result_reg (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .conv_done_i(done),
        .conv_raw_i (raw),
        .res_sel_i  (res),
        .rd_busy_i  (busy),
        .temp_word_o(temp_w),
        .cmp_word_o (cmp_w)
    );

    function automatic logic [15:0] expect_word(logic [11:0] r, logic [1:0] code);
        logic [15:0] low_mask;
        low_mask = 16'((32'd1 << (7 - int'(code))) - 1);
        return {r, 4'b0000} & ~low_mask;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        vec_cnt++;
        if (got !== exp) begin
            err_cnt++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // driver: one strobe per call, expected item pushed to the scoreboard
    task automatic convert(logic [11:0] r, logic [1:0] code, logic b, string tag);
        exp_item_t it;
        @(negedge clk);
        raw  = r;
        res  = code;
        busy = b;
        done = 1'b1;
        model_cmp = expect_word(r, code);
        if (!b) model_rd = model_cmp;
        it.cmp = model_cmp;
        it.rd  = model_rd;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            done = 1'b0;
            check({tag, " hold temp"}, temp_w, model_rd);
            check({tag, " hold cmp"},  cmp_w,  model_cmp);
        end
    endtask

    // monitor: note strobes at the edge, compare at the following negedge
    always @(posedge clk) pend <= done;

    always @(negedge clk) begin
        if (pend) begin
            if (sb_q.size() == 0) begin
                vec_cnt++;
                err_cnt++;
                $display("FAIL scoreboard empty: got %h expected item", temp_w);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check({it.tag, " cmp"},  cmp_w,  it.cmp);
                check({it.tag, " temp"}, temp_w, it.rd);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset temp", temp_w, 16'h0000);
        check("R1 reset cmp",  cmp_w,  16'h0000);
        rst_n = 1'b1;
        idle(2, "R1");

        convert(12'h7D0, 2'd3, 1'b0, "R2 positive full res");
        convert(12'hEB8, 2'd0, 1'b0, "R2 negative sign");
        convert(12'hFFF, 2'd0, 1'b0, "R3 code0 9 bits");
        convert(12'hFFF, 2'd1, 1'b0, "R3 code1 10 bits");
        convert(12'hFFF, 2'd2, 1'b0, "R3 code2 11 bits");
        convert(12'hFFF, 2'd3, 1'b0, "R3 code3 12 bits");
        convert(12'h5A5, 2'd2, 1'b0, "R5 unmasked update");
        idle(2, "R8 after update");

        convert(12'h123, 2'd3, 1'b1, "R4 R6 masked single");
        idle(1, "R6");
        convert(12'h456, 2'd3, 1'b1, "R6 masked run a");
        convert(12'h789, 2'd1, 1'b1, "R6 masked run b");
        convert(12'hC3C, 2'd3, 1'b0, "R7 first unmasked");
        idle(1, "R7");

        convert(12'h0F1, 2'd3, 1'b0, "R5 load");
        @(negedge clk);
        done = 1'b0;
        res  = 2'd0;
        idle(3, "R8 code change no strobe");
        convert(12'h0F1, 2'd0, 1'b0, "R8 new code applies");
        convert(12'h800, 2'd0, 1'b1, "R4 busy most negative");
        convert(12'h801, 2'd3, 1'b0, "R5 R2 most negative");
        idle(2, "R8 tail");

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end
endmodule